// File: doc/BRIEF.md
# Latched-Address Memory Cycle Engine

This block is the device-side control of a bytewide nonvolatile memory that presents an SRAM-like parallel bus. The bus has active-low chip select, read gate and write strobe, an address, and a data bus split into input, output and output-enable signals. All of it is sampled with a system clock. Every access starts only on a falling chip select. At that moment the address and the cycle kind (read or write) are captured. A fixed access interval then runs. Once started, that interval always runs to its end. After it comes a mandatory recovery (precharge) interval that begins once the chip select is released.

Read data goes onto the bus only after the access interval has finished, and only while the read gate is low. A write is stored at once, in the clock where the write strobe or the chip select rises, whichever comes first. There is no busy state. A write can be requested before the cycle begins, with the strobe already low at select time, or during a cycle that began as a read.

All control inputs pass through a two-stage synchronizer before edge detection. Address and write data pass through a matching two-stage delay, so they stay aligned with the controls. The full-size part uses `ADDR_W = 15` (32,768 bytes).

The controller is a four-state machine:
- ST_IDLE goes to ST_ACCESS on an accepted select fall.
- ST_ACCESS goes to ST_HOLD when the access count ends with the select still low, or to ST_PRECHARGE when the select was released during the access.
- ST_HOLD goes to ST_PRECHARGE on a select rise.
- ST_PRECHARGE goes to ST_IDLE when the recovery count ends.

Top module: `latched_nvm_engine`

## Requirements
- R1: The array stores 2**ADDR_W independent locations of DATA_W bits. Each location returns the last value written to it.
- R2: A cycle starts only on a synchronized high-to-low transition of `ce_n` seen in ST_IDLE. Holding `ce_n` low never starts a further cycle.
- R3: The address is captured when the cycle starts. Later changes on `addr` do not change which location the cycle reads or writes.
- R4: Number the clock edge that first samples `ce_n` low as edge 1. `dq_oe` stays low through edge ACCESS_CLKS+2. For a read with `oe_n` low, it rises at edge ACCESS_CLKS+3 with the stored byte on `dq_out`.
- R5: While `oe_n` is high, `dq_oe` is low. Whenever `dq_oe` is low, `dq_out` is all zeros.
- R6: If `we_n` is low when the cycle starts, the cycle is a write and `dq_oe` stays low for the whole cycle, whatever `oe_n` is. The stored byte is the `dq_in` value present at the first rise of `we_n` or `ce_n`.
- R7: A cycle that starts with `we_n` high is a read and drives according to `oe_n`. When `we_n` later falls, driving stops and the cycle becomes a write. The `dq_in` value at the next `we_n` rise is stored.
- R8: A cycle whose `ce_n` rises before the access interval ends still completes internally. A write in such a cycle is stored, and a read in such a cycle never drives the bus.
- R9: After release, the engine spends PRECHARGE_CLKS clocks in ST_PRECHARGE. A `ce_n` fall seen outside ST_IDLE is ignored and sets `pre_err`. `pre_err` clears when the next cycle is accepted.
- R10: A read may follow a write as soon as the recovery ends, and it returns the new value. No polling or busy interval exists.
- R11: After reset, `dq_oe` and `pre_err` are low and the engine is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select; its fall starts a cycle |
| oe_n | input | 1 | Active-low read gate for the data bus |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address, captured at cycle start |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus, zero when not driven |
| dq_oe | output | 1 | Bus drive enable |
| pre_err | output | 1 | Set by a select fall that came while the engine was busy |

## Verification
The hardest state to reach from the ports is a select fall that lands inside the recovery interval. The stimulus releases the select for a single clock right after a completed read. That makes the synchronized rise and fall arrive on consecutive edges, so the fall meets the engine in ST_PRECHARGE. The bench then holds the select low well past the recovery and confirms that no cycle starts. An early release inside the access interval is reached the same way: the select is lowered for one clock during a write, and a later read confirms the byte was still stored.

// File: rtl/nvm_engine_pkg.sv
package nvm_engine_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACCESS    = 2'd1,
        ST_HOLD      = 2'd2,
        ST_PRECHARGE = 2'd3
    } eng_state_t;

endpackage

// File: rtl/nvm_sync.sv
// Multi-stage register chain used both as a metastability synchronizer for
// control strobes and as a matching delay for address and data.
module nvm_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/nvm_edge.sv
// Rise/fall detector for an active-low strobe that idles high.
module nvm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= s;
        end
    end

    assign rise = s & ~prev_q;
    assign fall = ~s & prev_q;

endmodule

// File: rtl/nvm_array.sv
// Byte-wide storage with one write port and a registered read port.
module nvm_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/nvm_cycle_ctrl.sv
// Cycle sequencer: start on select fall, fixed access, hold, recovery.
module nvm_cycle_ctrl
    import nvm_engine_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int ACCESS_CLKS    = 4,
    parameter int PRECHARGE_CLKS = 4,
    parameter int CNT_W          = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_fall,
    input  logic              ce_rise,
    input  logic              we_s,
    input  logic              we_fall,
    input  logic              we_rise,
    input  logic              oe_s,
    input  logic [ADDR_W-1:0] addr_s,
    output eng_state_t        state,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              wr_mode,
    output logic              mem_we,
    output logic              rd_en,
    output logic              drive_en,
    output logic              pre_err
);

    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACCESS_CLKS - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRECHARGE_CLKS - 1);

    eng_state_t state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic wr_mode_q, wr_done_q, released_q, err_q;
    logic in_cycle, commit, start;

    assign in_cycle = (state_q == ST_ACCESS) || (state_q == ST_HOLD);
    assign start    = (state_q == ST_IDLE) && ce_fall;
    assign commit   = in_cycle && wr_mode_q && !wr_done_q && (we_rise || ce_rise);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ce_fall) state_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (cnt_q == ACC_LAST) begin
                    state_d = (released_q || ce_rise) ? ST_PRECHARGE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ce_rise) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                if (cnt_q == PRE_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            lat_addr_q <= '0;
            wr_mode_q  <= 1'b0;
            wr_done_q  <= 1'b0;
            released_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_ACCESS || state_q == ST_PRECHARGE) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (start) begin
                lat_addr_q <= addr_s;
                wr_mode_q  <= ~we_s;
                wr_done_q  <= 1'b0;
                released_q <= 1'b0;
                err_q      <= 1'b0;
            end else begin
                if (ce_fall) begin
                    err_q <= 1'b1;
                end
                if (in_cycle && we_fall && !wr_mode_q) begin
                    wr_mode_q <= 1'b1;
                end
                if (commit) begin
                    wr_done_q <= 1'b1;
                end
                if (state_q == ST_ACCESS && ce_rise) begin
                    released_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        state    = state_q;
        cnt      = cnt_q;
        lat_addr = lat_addr_q;
        wr_mode  = wr_mode_q;
        pre_err  = err_q;
        mem_we   = commit;
        rd_en    = (state_q == ST_ACCESS) && (cnt_q == ACC_LAST);
        drive_en = (state_q == ST_HOLD) && !wr_mode_q && !oe_s;
    end

endmodule

// File: rtl/latched_nvm_engine.sv
module latched_nvm_engine
    import nvm_engine_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int DATA_W         = 8,
    parameter int ACCESS_CLKS    = 4,
    parameter int PRECHARGE_CLKS = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              pre_err
);

    localparam int MAX_CNT = (ACCESS_CLKS > PRECHARGE_CLKS) ? ACCESS_CLKS : PRECHARGE_CLKS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int BUS_W   = ADDR_W + DATA_W;

    logic [2:0]        ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              ce_s, oe_s, we_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              ce_rise_w, ce_fall_w, we_rise_w, we_fall_w;
    eng_state_t        state_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [ADDR_W-1:0] lat_addr_w;
    logic              wr_mode_w, mem_we_w, rd_en_w, drive_w;
    logic [DATA_W-1:0] rd_q;

    nvm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) ctl_sync_i (
        .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(ctl_s)
    );

    nvm_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) bus_sync_i (
        .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_s)
    );

    assign ce_s   = ctl_s[2];
    assign oe_s   = ctl_s[1];
    assign we_s   = ctl_s[0];
    assign addr_s = bus_s[BUS_W-1:DATA_W];
    assign din_s  = bus_s[DATA_W-1:0];

    nvm_edge ce_edge_i (.clk(clk), .rst_n(rst_n), .s(ce_s), .rise(ce_rise_w), .fall(ce_fall_w));
    nvm_edge we_edge_i (.clk(clk), .rst_n(rst_n), .s(we_s), .rise(we_rise_w), .fall(we_fall_w));

    nvm_cycle_ctrl #(
        .ADDR_W(ADDR_W), .ACCESS_CLKS(ACCESS_CLKS),
        .PRECHARGE_CLKS(PRECHARGE_CLKS), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .ce_fall(ce_fall_w), .ce_rise(ce_rise_w),
        .we_s(we_s), .we_fall(we_fall_w), .we_rise(we_rise_w),
        .oe_s(oe_s), .addr_s(addr_s),
        .state(state_w), .cnt(cnt_w), .lat_addr(lat_addr_w),
        .wr_mode(wr_mode_w), .mem_we(mem_we_w), .rd_en(rd_en_w),
        .drive_en(drive_w), .pre_err(pre_err)
    );

    nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .we(mem_we_w), .waddr(lat_addr_w), .wdata(din_s),
        .re(rd_en_w), .raddr(lat_addr_w), .rdata(rd_q)
    );

    assign dq_oe  = drive_w;
    assign dq_out = drive_w ? rd_q : '0;

endmodule

// File: rtl/nvm_engine_chk.sv
module nvm_engine_chk
    import nvm_engine_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int CNT_W          = 3,
    parameter int ACCESS_CLKS    = 4,
    parameter int PRECHARGE_CLKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input eng_state_t        state,
    input logic [CNT_W-1:0]  cnt,
    input logic [ADDR_W-1:0] lat_addr,
    input logic              wr_mode,
    input logic              mem_we,
    input logic              ce_fall,
    input logic              oe_s,
    input logic              dq_oe,
    input logic              pre_err
);

    // R2
    start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && $past(state) == ST_IDLE) |-> $past(ce_fall));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(lat_addr));

    // R4
    access_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_ACCESS) |-> (int'($past(cnt)) == ACCESS_CLKS - 1));

    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_s);

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |-> !dq_oe);

    // R6
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9
    recovery_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_PRECHARGE) |-> (int'($past(cnt)) == PRECHARGE_CLKS - 1));

    // R9
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_err) |-> $past(state) != ST_IDLE);

endmodule

bind latched_nvm_engine nvm_engine_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .ACCESS_CLKS(ACCESS_CLKS), .PRECHARGE_CLKS(PRECHARGE_CLKS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .state(state_w), .cnt(cnt_w),
    .lat_addr(lat_addr_w), .wr_mode(wr_mode_w), .mem_we(mem_we_w),
    .ce_fall(ce_fall_w), .oe_s(oe_s), .dq_oe(dq_oe), .pre_err(pre_err)
);

// File: tb/latched_nvm_engine_tb.sv
module latched_nvm_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int ACC = 4;
    localparam int PRE = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, pre_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_nvm_engine #(
        .ADDR_W(AW), .DATA_W(DW), .ACCESS_CLKS(ACC), .PRECHARGE_CLKS(PRE), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .pre_err(pre_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Read with exact drive timing (R4): undriven through N(ACC+2), driven at N(ACC+3)
    task automatic do_read(input logic [AW-1:0] a, input string req);
        @(negedge clk); addr = a; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        for (int k = 1; k <= ACC + 2; k++) begin
            @(negedge clk);
            chk(dq_oe == 1'b0, "R4 early drive", int'(dq_oe), 0);
        end
        @(negedge clk);
        chk(dq_oe == 1'b1, "R4 drive at access end", int'(dq_oe), 1);
        chk(dq_out == ref_mem[a], req, int'(dq_out), int'(ref_mem[a]));
        ce_n = 1'b1;
        repeat (PRE + 4) @(negedge clk);
    endtask

    // Write with strobe low before select (R6)
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; dq_in = d; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        for (int k = 0; k < ACC + 3; k++) begin
            @(negedge clk);
            chk(dq_oe == 1'b0, "R6 write cycle driven", int'(dq_oe), 0);
        end
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        ref_mem[a] = d;
        repeat (PRE + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(dq_oe == 1'b0, "R11 dq_oe in reset", int'(dq_oe), 0);
        chk(pre_err == 1'b0, "R11 pre_err in reset", int'(pre_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0 && dq_out == '0, "R11 idle bus", int'(dq_out), 0);

        // R1 sweep: every location written with an arithmetic pattern, then read
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), DW'((a * 37 + 5) & 8'hFF));
        for (int a = 0; a < DEPTH; a++) do_read(AW'(a), "R1 sweep readback");

        // R5: read gate high, bus never driven
        @(negedge clk); addr = 6'd9; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        for (int k = 0; k < ACC + 8; k++) begin
            @(negedge clk);
            chk(dq_oe == 1'b0 && dq_out == '0, "R5 oe high keeps bus off", int'(dq_out), 0);
        end
        ce_n = 1'b1;
        repeat (PRE + 4) @(negedge clk);

        // R3: address changes after the start are ignored
        @(negedge clk); addr = 6'd12; oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); addr = 6'd40;
        repeat (ACC + 2) @(negedge clk);
        chk(dq_out == ref_mem[12], "R3 latched address", int'(dq_out), int'(ref_mem[12]));
        repeat (6) @(negedge clk);
        chk(dq_oe == 1'b1 && dq_out == ref_mem[12], "R3 still latched", int'(dq_out), int'(ref_mem[12]));
        ce_n = 1'b1;
        repeat (PRE + 4) @(negedge clk);

        // R7: cycle starts as a read, strobe falls later, converts to write
        @(negedge clk); addr = 6'd20; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        repeat (ACC + 3) @(negedge clk);
        chk(dq_oe == 1'b1 && dq_out == ref_mem[20], "R7 starts as read", int'(dq_out), int'(ref_mem[20]));
        we_n = 1'b0; dq_in = 8'hA5;
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R7 drive stops on strobe fall", int'(dq_oe), 0);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R7 no drive after conversion", int'(dq_oe), 0);
        ce_n = 1'b1;
        ref_mem[20] = 8'hA5;
        repeat (PRE + 4) @(negedge clk);
        do_read(6'd20, "R7 converted write stored");

        // R8: select held low for one clock only during a write
        @(negedge clk); addr = 6'd33; dq_in = 8'h3C; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); ce_n = 1'b1;
        for (int k = 0; k < ACC + 4; k++) begin
            @(negedge clk);
            chk(dq_oe == 1'b0, "R8 early release write no drive", int'(dq_oe), 0);
        end
        we_n = 1'b1;
        ref_mem[33] = 8'h3C;
        repeat (PRE + 4) @(negedge clk);
        do_read(6'd33, "R8 early release write stored");

        // R8: early release read never drives
        @(negedge clk); addr = 6'd33; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); ce_n = 1'b1;
        for (int k = 0; k < ACC + PRE + 6; k++) begin
            @(negedge clk);
            chk(dq_oe == 1'b0, "R8 early release read no drive", int'(dq_oe), 0);
        end

        // R9 / R2: select fall during recovery is ignored and flagged
        @(negedge clk); addr = 6'd5; oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        repeat (ACC + 3) @(negedge clk);
        chk(dq_oe == 1'b1, "R9 setup read driven", int'(dq_oe), 1);
        ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(pre_err == 1'b1, "R9 fall in recovery flagged", int'(pre_err), 1);
        for (int k = 0; k < 2 * ACC + PRE + 10; k++) begin
            @(negedge clk);
            chk(dq_oe == 1'b0, "R2 held-low select starts no cycle", int'(dq_oe), 0);
        end
        chk(pre_err == 1'b1, "R9 flag sticky", int'(pre_err), 1);
        ce_n = 1'b1;
        repeat (PRE + 4) @(negedge clk);
        do_read(6'd5, "R9 read after ignored fall");
        chk(pre_err == 1'b0, "R9 flag cleared on accepted cycle", int'(pre_err), 0);

        // R10: back-to-back write/read pairs with computed values
        lcg = 32'h1234_5678;
        for (int n = 0; n < 40; n++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg[AW+7:8];
            d = lcg[31:24];
            do_write(a, d);
            do_read(a, "R10 read after write");
            if (n % 4 == 3) do_read(AW'(lcg[21:16]), "R10 random read");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule